// File: doc/BRIEF.md
# Fail-safe clock source controller

This block decides which clock drives the CPU and the peripherals of a small microcontroller. There are three candidate sources: the main crystal oscillator, a slow internal ring oscillator and a PLL that multiplies the main clock. The block holds the enable and select bits for each source. It keeps a PLL multiply code that can be set only once. It runs a settling count before the PLL may be selected. It checks requests for the low-power modes.

The oscillators are modelled as activity strobes. `main_edge_i` pulses for each main-clock edge seen, and `ring_tick_i` pulses for each ring-oscillator cycle. When the stop watch is armed and the main clock goes quiet for `FAIL_TICKS` ring cycles, the block moves the CPU to the ring oscillator on its own, raises a one-cycle interrupt and keeps a sticky stop flag. The source choice is a registered 2-bit code, and a glitch-free mux outside the block uses it.

Writes arrive on a simple one-cycle write strobe:

| Address | Contents |
|---|---|
| 0 (control) | bit0 ring select, bit1 PLL run, bit2 PLL select, bit3 stop-watch enable, bit4 stop-interrupt mode |
| 1 | PLL multiply code, bits [2:0] |
| 2 | settle count load, all `DATA_W` bits |
| 3 (low-power request) | bit0 wait, bit1 stop |

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset, `src_sel_o` is 0 (main), `ring_en_o`, `pll_en_o`, `pll_ready_o`, `osc_stop_o`, `osc_irq_o`, `lp_err_o`, `wait_ok_o` and `stop_ok_o` are 0, and `pll_mult_o` is 0.
- R2: Writing 1 to control bit0 turns the ring oscillator on (`ring_en_o`=1) and sets `src_sel_o` to 1 (ring). The ring select takes priority over the PLL select.
- R3: The stop watch is armed only when control bit3 and bit4 are both 1. Once it is armed, a run of `FAIL_TICKS` ring ticks with no main edge causes three effects: a single-cycle `osc_irq_o` pulse, a sticky `osc_stop_o`, and the ring select is forced to 1. When the watch is not armed, a silent main clock has no effect.
- R4: Writing 1 to control bit1 starts the PLL (`pll_en_o`=1) and loads the settle counter from the value at address 2. The counter decrements once per main edge. `pll_ready_o` rises after the counter reaches zero. Once ready, PLL select with ring select 0 gives `src_sel_o`=2.
- R5: A write of 1 to PLL select while `pll_ready_o` is 0 is ignored.
- R6: Only the first write to address 1 after reset sets `pll_mult_o`. Later writes are ignored. Code 3'b001 means ×2 and 3'b010 means ×4.
- R7: A write to address 3 is handled as follows. Bit1 is a stop request, which is granted (a `stop_ok_o` pulse) only when both PLL select and PLL run are 0. Otherwise bit0 is a wait request, which is granted (a `wait_ok_o` pulse) only when PLL select is 0. A refused request gives no grant and sets the sticky `lp_err_o`.
- R8: Clearing PLL run forces PLL select to 0, so `src_sel_o` falls back. It also clears `pll_ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | DATA_W | Write data |
| main_edge_i | input | 1 | Main-clock activity strobe |
| ring_tick_i | input | 1 | Ring-oscillator cycle strobe |
| src_sel_o | output | 2 | Clock source: 0 main, 1 ring, 2 PLL |
| ring_en_o | output | 1 | Ring oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| pll_mult_o | output | 3 | PLL multiply code |
| pll_ready_o | output | 1 | PLL settling done |
| osc_stop_o | output | 1 | Sticky main-clock stop flag |
| osc_irq_o | output | 1 | One-cycle stop interrupt |
| lp_err_o | output | 1 | Sticky illegal low-power request flag |
| wait_ok_o | output | 1 | Wait-mode grant pulse |
| stop_ok_o | output | 1 | Stop-mode grant pulse |

## Verification
The assertions check four things on every cycle: the PLL is never selected without ready, the multiply code stays frozen once locked, each interrupt lasts a single cycle, and a stop grant never comes while the PLL runs. They also check that ready drops after the PLL is switched off. The bench scenarios cover behaviour that depends on history and timing. These are the settle duration counted in main edges, the silent-clock timeout in ring ticks with and without arming, the fallback source after a failure, and the grant or refusal of random low-power requests.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_RING = 2'd1,
    SRC_PLL  = 2'd2
  } clk_src_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_MULT   = 2'd1;
  localparam logic [1:0] ADDR_SETTLE = 2'd2;
  localparam logic [1:0] ADDR_LP     = 2'd3;

  localparam int CB_RING   = 0;
  localparam int CB_PLLON  = 1;
  localparam int CB_PLLSEL = 2;
  localparam int CB_OSDEN  = 3;
  localparam int CB_OSDIRQ = 4;
  localparam int CTRL_BITS = 5;

  localparam int LB_WAIT = 0;
  localparam int LB_STOP = 1;

  localparam int MULT_W = 3;
endpackage

// File: rtl/clk_src_settle.sv
module clk_src_settle #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             tick_i,
  output logic             ready_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      en_q    <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        cnt_q   <= '0;
        busy_q  <= 1'b0;
        ready_o <= 1'b0;
      end else if (!en_q) begin
        cnt_q   <= load_i;
        busy_q  <= 1'b1;
        ready_o <= 1'b0;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q  <= 1'b0;
          ready_o <= 1'b1;
        end else if (tick_i) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  AST_OFF_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ready_o); // R8
  AST_READY_AFTER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(busy_q) && $past(cnt_q) == '0); // R4
endmodule

// File: rtl/clk_src_watch.sv
module clk_src_watch #(
  parameter int FAIL_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic main_edge_i,
  input  logic ring_tick_i,
  output logic fire_o
);
  localparam int CNT_W = $clog2(FAIL_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FAIL_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tripped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      tripped_q <= 1'b0;
      fire_o    <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (!armed_i || main_edge_i) begin
        cnt_q     <= '0;
        tripped_q <= 1'b0;
      end else if (ring_tick_i && !tripped_q) begin
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          tripped_q <= 1'b1;
          fire_o    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(armed_i) && !$past(main_edge_i)); // R3
  AST_FIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o); // R3
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FAIL_TICKS = 8,
  parameter int SETTLE_RST = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              main_edge_i,
  input  logic              ring_tick_i,
  output logic [1:0]        src_sel_o,
  output logic              ring_en_o,
  output logic              pll_en_o,
  output logic [2:0]        pll_mult_o,
  output logic              pll_ready_o,
  output logic              osc_stop_o,
  output logic              osc_irq_o,
  output logic              lp_err_o,
  output logic              wait_ok_o,
  output logic              stop_ok_o
);
  logic              ring_sel_q, pll_on_q, pll_sel_q, osd_en_q, osd_irq_q;
  logic [MULT_W-1:0] mult_q;
  logic              mult_lock_q;
  logic [DATA_W-1:0] settle_q;
  logic              armed, fire, ready;
  logic              wr_ctrl, wr_mult, wr_settle, wr_lp;
  clk_src_e          src_q;
  logic              unused_data;

  assign unused_data = ^wr_data_i[DATA_W-1:CTRL_BITS];

  assign wr_ctrl   = wr_en_i && wr_addr_i == ADDR_CTRL;
  assign wr_mult   = wr_en_i && wr_addr_i == ADDR_MULT;
  assign wr_settle = wr_en_i && wr_addr_i == ADDR_SETTLE;
  assign wr_lp     = wr_en_i && wr_addr_i == ADDR_LP;
  assign armed     = osd_en_q && osd_irq_q;

  clk_src_settle #(.CNT_W(DATA_W)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (pll_on_q),
    .load_i  (settle_q),
    .tick_i  (main_edge_i),
    .ready_o (ready)
  );

  clk_src_watch #(.FAIL_TICKS(FAIL_TICKS)) u_watch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .armed_i     (armed),
    .main_edge_i (main_edge_i),
    .ring_tick_i (ring_tick_i),
    .fire_o      (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_sel_q <= 1'b0;
      pll_on_q   <= 1'b0;
      pll_sel_q  <= 1'b0;
      osd_en_q   <= 1'b0;
      osd_irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ring_sel_q <= wr_data_i[CB_RING] | fire;
        pll_on_q   <= wr_data_i[CB_PLLON];
        // select only takes a new value once settled; PLL off forces it low
        pll_sel_q  <= wr_data_i[CB_PLLON] &
                      (ready ? wr_data_i[CB_PLLSEL] : pll_sel_q);
        osd_en_q   <= wr_data_i[CB_OSDEN];
        osd_irq_q  <= wr_data_i[CB_OSDIRQ];
      end else if (fire) begin
        ring_sel_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_q      <= '0;
      mult_lock_q <= 1'b0;
      settle_q    <= DATA_W'(SETTLE_RST);
    end else begin
      if (wr_mult && !mult_lock_q) begin
        mult_q      <= wr_data_i[MULT_W-1:0];
        mult_lock_q <= 1'b1;
      end
      if (wr_settle) settle_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_ok_o  <= 1'b0;
      stop_ok_o  <= 1'b0;
      lp_err_o   <= 1'b0;
      osc_stop_o <= 1'b0;
    end else begin
      wait_ok_o <= 1'b0;
      stop_ok_o <= 1'b0;
      if (fire) osc_stop_o <= 1'b1;
      if (wr_lp) begin
        if (wr_data_i[LB_STOP]) begin
          if (!pll_sel_q && !pll_on_q) stop_ok_o <= 1'b1;
          else                         lp_err_o  <= 1'b1;
        end else if (wr_data_i[LB_WAIT]) begin
          if (!pll_sel_q) wait_ok_o <= 1'b1;
          else            lp_err_o  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (ring_sel_q)     src_q = SRC_RING;
    else if (pll_sel_q) src_q = SRC_PLL;
    else                src_q = SRC_MAIN;
  end

  assign src_sel_o   = src_q;
  assign ring_en_o   = ring_sel_q | armed;
  assign pll_en_o    = pll_on_q;
  assign pll_mult_o  = mult_q;
  assign pll_ready_o = ready;
  assign osc_irq_o   = fire;

  AST_SEL_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_sel_q |-> ready); // R5
  AST_MULT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mult_lock_q && $past(mult_lock_q) |-> $stable(mult_q)); // R6
  AST_STOP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ok_o |-> !pll_on_q && !pll_sel_q); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_err_o |=> lp_err_o); // R7
  AST_FAIL_TO_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_irq_o |=> osc_stop_o && src_sel_o == SRC_RING); // R3
  AST_RING_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_sel_o == SRC_RING |-> ring_en_o); // R2
endmodule

// File: tb/clk_src_ctrl_test.sv
module clk_src_ctrl_test;
  localparam int DATA_W = 16;
  localparam int FAIL_TICKS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic main_edge = 1'b0, ring_tick = 1'b0;
  logic main_run = 1'b1;
  int   ring_div = 0;
  logic [1:0] src_sel;
  logic ring_en, pll_en, pll_ready, osc_stop, osc_irq, lp_err, wait_ok, stop_ok;
  logic [2:0] pll_mult;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  clk_src_ctrl #(.DATA_W(DATA_W), .FAIL_TICKS(FAIL_TICKS), .SETTLE_RST(256)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .main_edge_i(main_edge), .ring_tick_i(ring_tick),
    .src_sel_o(src_sel), .ring_en_o(ring_en), .pll_en_o(pll_en),
    .pll_mult_o(pll_mult), .pll_ready_o(pll_ready), .osc_stop_o(osc_stop),
    .osc_irq_o(osc_irq), .lp_err_o(lp_err), .wait_ok_o(wait_ok), .stop_ok_o(stop_ok)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    main_edge <= main_run;
    ring_tick <= (ring_div == 0);
    ring_div  <= (ring_div == 3) ? 0 : ring_div + 1;
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int exp_src(bit ring, bit sel);
    return ring ? 1 : (sel ? 2 : 0);
  endfunction

  function automatic logic [DATA_W-1:0] ctrl(bit ring, bit on, bit sel, bit en, bit irq);
    return DATA_W'({irq, en, sel, on, ring});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] first;
    int irqs;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 src", src_sel, 0);
    check("R1 ring_en", ring_en, 0);
    check("R1 pll_en", pll_en, 0);
    check("R1 ready", pll_ready, 0);
    check("R1 flags", {osc_stop, osc_irq, lp_err, wait_ok, stop_ok}, 0);
    check("R1 mult", pll_mult, 0);

    // R6 write-once multiply code
    first = 3'($urandom_range(1, 2));
    wr(2'd1, DATA_W'(first));
    check("R6 first", pll_mult, first);
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, DATA_W'($urandom_range(0, 7)));
      check("R6 locked", pll_mult, first);
    end

    // R4/R5 settle and select
    wr(2'd2, DATA_W'(10));
    wr(2'd0, ctrl(0, 1, 0, 0, 0));
    check("R4 pll_en", pll_en, 1);
    check("R4 not ready", pll_ready, 0);
    wr(2'd0, ctrl(0, 1, 1, 0, 0));
    check("R5 early select ignored", src_sel, 0);
    repeat (4) @(negedge clk);
    check("R4 still settling", pll_ready, 0);
    repeat (12) @(negedge clk);
    check("R4 ready", pll_ready, 1);
    wr(2'd0, ctrl(0, 1, 1, 0, 0));
    check("R4 pll src", src_sel, 2);

    // R7 wait refused with PLL selected
    wr(2'd3, DATA_W'(1));
    check("R7 wait refused", wait_ok, 0);
    check("R7 err", lp_err, 1);

    // R2 ring over PLL
    wr(2'd0, ctrl(1, 1, 1, 0, 0));
    check("R2 ring src", src_sel, 1);
    check("R2 ring_en", ring_en, 1);

    // random control/low-power mix with PLL running
    for (int i = 0; i < 24; i++) begin
      bit r = 1'($urandom_range(0, 1));
      bit s = 1'($urandom_range(0, 1));
      bit stp = 1'($urandom_range(0, 1));
      wr(2'd0, ctrl(r, 1, s, 0, 0));
      check("R2 rand src", src_sel, exp_src(r, s));
      check("R2 rand ring_en", ring_en, r);
      wr(2'd3, stp ? DATA_W'(2) : DATA_W'(1));
      check("R7 rand stop", stop_ok, 0);
      check("R7 rand wait", wait_ok, (!stp && !s) ? 1 : 0);
    end

    // R8 PLL off drops select and ready
    wr(2'd0, ctrl(0, 1, 1, 0, 0));
    check("R8 pre", src_sel, 2);
    wr(2'd0, ctrl(0, 0, 1, 0, 0));
    check("R8 src back to main", src_sel, 0);
    @(negedge clk);
    check("R8 ready cleared", pll_ready, 0);
    wr(2'd3, DATA_W'(2));
    check("R7 stop granted", stop_ok, 1);
    wr(2'd3, DATA_W'(1));
    check("R7 wait granted", wait_ok, 1);

    // R3 unarmed: silent main clock does nothing
    wr(2'd0, ctrl(0, 0, 0, 1, 0));
    main_run = 1'b0;
    irqs = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (osc_irq) irqs++;
    end
    check("R3 unarmed irq", irqs, 0);
    check("R3 unarmed stop", osc_stop, 0);
    check("R3 unarmed src", src_sel, 0);

    // R3 armed: fallback to ring
    wr(2'd0, ctrl(0, 0, 0, 1, 1));
    irqs = 0;
    for (int i = 0; i < 4 * (FAIL_TICKS - 1); i++) begin
      @(negedge clk);
      if (osc_irq) irqs++;
    end
    check("R3 no early irq", irqs, 0);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (osc_irq) irqs++;
    end
    check("R3 single irq", irqs, 1);
    check("R3 stop flag", osc_stop, 1);
    check("R3 ring src", src_sel, 1);
    main_run = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 sticky", osc_stop, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule